// File: doc/BRIEF.md
# Selectable-Order Burst Address Counter

This block produces the word address for a four-beat burst into a synchronous memory array. When an address-strobe cycle occurs, it captures a full external address. The high part of that address is held fixed for the rest of the burst. The two low bits become the start point of a small sequencer. On later cycles, when no strobe is active, an active-low advance input either steps the low bits to the next beat or keeps them where they are.

A static order-select input chooses between two step orders. The first is wrap-around linear counting, which adds one modulo four. The second is interleaved counting, where the start value is XORed with a running beat count. The order-select input is not registered, so a change on it shows on the output without waiting for a clock edge. The output is the held upper address joined with the two sequenced bits. The array, the byte-write logic and the read pipeline sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low at a rising edge, the stored address and the beat count are cleared, so word_addr reads 0 after that edge.
- R2: If load_a_n or load_b_n is low at a rising edge, word_addr equals the addr_in sampled at that edge from the next cycle on. This applies to either strobe alone or to both together.
- R3: A load restarts the beat count at zero, even in the middle of a burst. The low bits after the load are exactly addr_in[1:0].
- R4: With both strobes high and step_n low at a rising edge, the low two bits of word_addr move to the next beat of the selected order.
- R5: With both strobes high and step_n high at a rising edge, word_addr keeps its value, as long as order_sel is unchanged.
- R6: With order_sel = 0 (linear), beat n of a burst that started at s has low bits (s + n) mod 4. For example, s = 2 gives 2,3,0,1 and s = 3 gives 3,0,1,2.
- R7: With order_sel = 1 (interleaved), beat n of a burst that started at s has low bits s XOR n. For example, s = 1 gives 1,0,3,2 and s = 3 gives 3,2,1,0.
- R8: Advancing never changes word_addr[15:2]. No carry leaves the two sequenced bits.
- R9: A strobe has priority over the advance input. When a strobe and step_n are both low in the same cycle, the block loads and does not advance.
- R10: After the fourth advance the sequence wraps back to the start value and keeps going while step_n stays low. No end-of-burst indication is produced.
- R11: order_sel is combinational. Changing it between edges remaps the current beat at once, so the low bits go from (s + n) mod 4 to s XOR n with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_a_n | input | 1 | First address strobe, active low |
| load_b_n | input | 1 | Second address strobe, active low |
| step_n | input | 1 | Advance input, active low; only used when both strobes are high |
| order_sel | input | 1 | Static order strap: 0 linear, 1 interleaved |
| addr_in | input | 16 | External word address |
| word_addr | output | 16 | Full array address: held upper bits and sequenced low bits |

## Verification
The two functions that can fall in the same cycle are loading a new address and advancing the current burst. Either strobe can be low while step_n is also low. The bench sets this up partway through a burst, after a few advances, by driving a new address with both a strobe and step_n low. It then requires the next output to be exactly the new address at beat zero, neither advanced nor mixed with the old count. It also requires the following advances to count from that new start. The strap and the beat state can also interact between edges. The bench flips order_sel during a hold and compares the output against both ordering formulas with no clock edge in between.

// File: rtl/burst_addr_pkg.sv
// Package: shared widths and the beat-to-address mapping helper for the
// burst address counter. Assumes the burst length is a power of two.
package burst_addr_pkg;

    // Encoding of the ordering strap.
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    // Returns the low address bits for a given start value and beat count.
    function automatic logic [1:0] map_beat2(input logic [1:0] start,
                                             input logic [1:0] beat,
                                             input order_e     ord);
        logic [1:0] res;
        if (ord == ORD_XOR) res = start ^ beat;
        else                res = start + beat;
        return res;
    endfunction

endpackage

// File: rtl/burst_upper_reg.sv
// Upper address holder: captures the high part of the external address on
// a load cycle and keeps it constant for the whole burst.
// Assumes the load qualifier is already decoded from the strobes.
module burst_upper_reg #(
    parameter int UW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [UW-1:0] upper_in,
    output logic [UW-1:0] upper_q
);

    // Capture or hold the high address bits.
    always_ff @(posedge clk) begin
        if (!rst_n)    upper_q <= '0;
        else if (load) upper_q <= upper_in;
    end

endmodule

// File: rtl/burst_beat_ctr.sv
// Beat state: stores the burst start value and a beat counter that
// restarts on load and steps modulo 2**LW on advance. Load wins over
// advance. Assumes load and adv are never requested by a reset cycle.
module burst_beat_ctr #(
    parameter int LW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  logic [LW-1:0] start_in,
    output logic [LW-1:0] start_q,
    output logic [LW-1:0] beat_q
);

    localparam logic [LW-1:0] BEAT_ONE = LW'(1);

    // Start value register: captured only on load.
    always_ff @(posedge clk) begin
        if (!rst_n)    start_q <= '0;
        else if (load) start_q <= start_in;
    end

    // Beat counter: cleared on load, incremented on advance, wraps freely.
    always_ff @(posedge clk) begin
        if (!rst_n)      beat_q <= '0;
        else if (load)   beat_q <= '0;
        else if (adv)    beat_q <= beat_q + BEAT_ONE;
    end

endmodule

// File: rtl/burst_order_map.sv
// Order mapper: turns start value and beat count into the low address
// bits. Linear order adds, interleaved order XORs. Purely combinational,
// so the strap reaches the output without a register.
module burst_order_map #(
    parameter int LW = 2
) (
    input  logic          ord_xor,
    input  logic [LW-1:0] start_q,
    input  logic [LW-1:0] beat_q,
    output logic [LW-1:0] low_addr
);

    import burst_addr_pkg::*;

    generate
        if (LW == 2) begin : g_pkg_map
            // Two-bit case uses the shared package helper.
            always_comb begin
                low_addr = map_beat2(start_q, beat_q,
                                     ord_xor ? ORD_XOR : ORD_LINEAR);
            end
        end else begin : g_gen_map
            logic [LW-1:0] lin_sum;
            logic [LW-1:0] xor_mix;
            // Generic widths: compute both orders and select by strap.
            always_comb begin
                lin_sum  = start_q + beat_q;
                xor_mix  = start_q ^ beat_q;
                low_addr = ord_xor ? xor_mix : lin_sum;
            end
        end
    endgenerate

endmodule

// File: rtl/burst_addr_gen.sv
// Top: burst address generator. Decodes the two active-low strobes and
// the active-low advance input, holds the upper address, sequences the
// low bits and concatenates them into the array word address.
// Assumes order_sel is a static strap; it is not registered here.
module burst_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int LOW_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_a_n,
    input  logic              load_b_n,
    input  logic              step_n,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] word_addr
);

    localparam int UP_W = ADDR_W - LOW_W;

    logic             load_req;
    logic             adv_req;
    logic [UP_W-1:0]  upper_q;
    logic [LOW_W-1:0] start_q;
    logic [LOW_W-1:0] beat_q;
    logic [LOW_W-1:0] low_addr;

    // Strobe and advance decode: any strobe loads, advance only when idle.
    always_comb begin
        load_req = !load_a_n || !load_b_n;
        adv_req  = !load_req && !step_n;
    end

    burst_upper_reg #(.UW(UP_W)) u_upper (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_req),
        .upper_in (addr_in[ADDR_W-1:LOW_W]),
        .upper_q  (upper_q)
    );

    burst_beat_ctr #(.LW(LOW_W)) u_beat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_req),
        .adv      (adv_req),
        .start_in (addr_in[LOW_W-1:0]),
        .start_q  (start_q),
        .beat_q   (beat_q)
    );

    burst_order_map #(.LW(LOW_W)) u_map (
        .ord_xor  (order_sel),
        .start_q  (start_q),
        .beat_q   (beat_q),
        .low_addr (low_addr)
    );

    // Output assembly: fixed upper part joined with sequenced low bits.
    always_comb begin
        word_addr = {upper_q, low_addr};
    end

endmodule

// File: rtl/burst_addr_gen_chk.sv
// Checker: port-level temporal properties of the burst address generator.
module burst_addr_gen_chk #(
    parameter int ADDR_W = 16,
    parameter int LOW_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_a_n,
    input logic              load_b_n,
    input logic              step_n,
    input logic              order_sel,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] word_addr
);

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_a_n || !load_b_n) |=> (word_addr == $past(addr_in)));

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_a_n && load_b_n && step_n) |=>
        ($stable(word_addr) || !$stable(order_sel)));

    // R8
    upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_a_n && load_b_n) |=>
        (word_addr[ADDR_W-1:LOW_W] == $past(word_addr[ADDR_W-1:LOW_W])));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_a_n && load_b_n && !step_n && !order_sel) |=>
        (order_sel ||
         word_addr[LOW_W-1:0] == $past(word_addr[LOW_W-1:0]) + LOW_W'(1)));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_a_n  (load_a_n),
    .load_b_n  (load_b_n),
    .step_n    (step_n),
    .order_sel (order_sel),
    .addr_in   (addr_in),
    .word_addr (word_addr)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_a_n = 1'b1;
    logic        load_b_n = 1'b1;
    logic        step_n = 1'b1;
    logic        order_sel = 1'b0;
    logic [15:0] addr_in = 16'h0;
    logic [15:0] word_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    burst_addr_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_a_n  (load_a_n),
        .load_b_n  (load_b_n),
        .step_n    (step_n),
        .order_sel (order_sel),
        .addr_in   (addr_in),
        .word_addr (word_addr)
    );

    function automatic logic [15:0] model(input logic [15:0] base,
                                          input int n, input logic mode);
        logic [1:0] lo;
        logic [1:0] nb;
        nb = 2'(n);
        lo = mode ? (base[1:0] ^ nb) : (base[1:0] + nb);
        return {base[15:2], lo};
    endfunction

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, then sample 1 ns after rising edge.
    task automatic cyc(input logic a_n, input logic b_n, input logic s_n,
                       input logic [15:0] ad);
        @(negedge clk);
        load_a_n = a_n; load_b_n = b_n; step_n = s_n; addr_in = ad;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        cyc(1'b0, 1'b1, 1'b1, 16'hBEEF);
        rst_n = 1'b0;
        cyc(1'b1, 1'b1, 1'b1, 16'h0);
        check("R1 reset clears", word_addr, 16'h0000);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_load_each();
        cyc(1'b0, 1'b1, 1'b1, 16'h1235);
        check("R2 load via strobe a", word_addr, 16'h1235);
        cyc(1'b1, 1'b0, 1'b1, 16'hA5F2);
        check("R2 load via strobe b", word_addr, 16'hA5F2);
        cyc(1'b0, 1'b0, 1'b1, 16'h7C03);
        check("R2 load via both strobes", word_addr, 16'h7C03);
    endtask

    task automatic t_linear(input logic [15:0] base);
        order_sel = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, base);
        check("R6 linear beat0", word_addr, model(base, 0, 1'b0));
        for (int i = 1; i <= 6; i++) begin
            cyc(1'b1, 1'b1, 1'b0, 16'hFFFF);
            check(i == 4 ? "R10 wrap to start" : "R6 R4 R8 linear step",
                  word_addr, model(base, i, 1'b0));
        end
    endtask

    task automatic t_interleave(input logic [15:0] base);
        order_sel = 1'b1;
        cyc(1'b1, 1'b0, 1'b1, base);
        check("R7 interleaved beat0", word_addr, model(base, 0, 1'b1));
        for (int i = 1; i <= 5; i++) begin
            cyc(1'b1, 1'b1, 1'b0, 16'h0000);
            check(i == 4 ? "R10 interleaved wrap" : "R7 R4 interleaved step",
                  word_addr, model(base, i, 1'b1));
        end
    endtask

    task automatic t_hold();
        order_sel = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, 16'h4442);
        cyc(1'b1, 1'b1, 1'b0, 16'h0);
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b1, 1'b1, 16'h9999);
            check("R5 hold with step high", word_addr, model(16'h4442, 1, 1'b0));
        end
        cyc(1'b1, 1'b1, 1'b0, 16'h0);
        check("R5 resume after hold", word_addr, model(16'h4442, 2, 1'b0));
    endtask

    task automatic t_priority();
        order_sel = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, 16'h3331);
        cyc(1'b1, 1'b1, 1'b0, 16'h0);
        cyc(1'b1, 1'b1, 1'b0, 16'h0);
        cyc(1'b0, 1'b1, 1'b0, 16'h8882);
        check("R9 R3 load beats advance", word_addr, 16'h8882);
        cyc(1'b1, 1'b1, 1'b0, 16'h0);
        check("R3 count restarts", word_addr, model(16'h8882, 1, 1'b0));
        cyc(1'b1, 1'b0, 1'b0, 16'h5551);
        check("R9 strobe b beats advance", word_addr, 16'h5551);
    endtask

    task automatic t_mode_live();
        order_sel = 1'b0;
        cyc(1'b0, 1'b1, 1'b1, 16'h2223);
        cyc(1'b1, 1'b1, 1'b0, 16'h0);
        cyc(1'b1, 1'b1, 1'b1, 16'h0);
        check("R11 linear view", word_addr, model(16'h2223, 1, 1'b0));
        #0.5 order_sel = 1'b1;
        #0.5;
        check("R11 strap remaps without edge", word_addr, model(16'h2223, 1, 1'b1));
        cyc(1'b1, 1'b1, 1'b0, 16'h0);
        check("R11 R7 continue interleaved", word_addr, model(16'h2223, 2, 1'b1));
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset state", word_addr, 16'h0000);
        @(negedge clk); rst_n = 1'b1;
        t_load_each();
        t_linear(16'hC0DA);
        t_linear(16'h0017);
        t_interleave(16'h1101);
        t_interleave(16'hF00F);
        t_interleave(16'h6662);
        t_hold();
        t_priority();
        t_mode_live();
        t_reset();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule